// File: doc/BRIEF.md
# Ordering Table Clear Engine

This block builds an empty, reverse-linked ordering table in memory without reading anything. Software loads a start address, an entry count and a control word, then pulses `start`. If the control word matches the one accepted fill code, the engine writes a run of 32-bit entries, walking downward through memory one word at a time. Every entry holds a pointer to the word just below it. The entry at the lowest address holds an end marker instead. When the last entry has been accepted, the engine clears the run flag in its copy of the control word and pulses `irq`.

Entries leave through a valid/ready write port. The engine raises `wr_valid` and keeps `wr_addr` and `wr_data` fixed until the memory side answers with `wr_ready`. A write is accepted in every cycle where both signals are high, so the memory can hold back the engine for any number of cycles. The memory side must not make `wr_ready` depend on `wr_valid` combinationally. The engine does not need that either: `wr_valid` does not depend on `wr_ready` in the same cycle. A control word that does not match, or a count of zero, ends the request at once with no writes.

Top module: `otc_clear_engine`

## Requirements
- R1: A `start` pulse while idle, with `ctrl_word` equal to 0x11000002 and a nonzero `entry_count`, makes `busy` and `wr_valid` high from the next cycle.
- R2: A `start` pulse while idle with any other `ctrl_word` produces no write. `irq` is high in the next cycle for one cycle, and `ctrl_out` then equals that control word with bit 24 cleared.
- R3: An accepted request produces exactly `entry_count` accepted writes. The count is the number of 32-bit entries, with no block multiplication.
- R4: The first write goes to `base_addr`. Each later write goes to the previous address minus 4, modulo 2^24.
- R5: Every entry except the last carries its own address minus 4, taken modulo 2^24, in bits 23:0. Bits 31:24 of the entry are zero.
- R6: The last entry, at the lowest address, carries 0x00FFFFFF.
- R7: In the cycle after the final write is accepted, `busy` is low and `irq` is high for exactly one cycle. `ctrl_out` then holds the accepted control word with bit 24 cleared.
- R8: An accepted code with `entry_count` of zero produces no write. `irq` pulses in the next cycle, and bit 24 of `ctrl_out` is cleared.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. One entry is accepted in each cycle in which both are high.
- R10: `busy` stays high from the cycle after an accepted start through the cycle in which the final write is accepted. A `start` pulse while busy has no effect on the writes, on `irq` or on `ctrl_out`.
- R11: During and right after reset, `wr_valid`, `busy` and `irq` are low and `ctrl_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; sampled only while idle |
| base_addr | input | 24 | Address of the highest (first written) entry |
| entry_count | input | 16 | Number of 32-bit entries to write |
| ctrl_word | input | 32 | Control word; only 0x11000002 starts a fill |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| wr_addr | output | 24 | Byte address of the entry being written |
| wr_data | output | 32 | Entry contents |
| busy | output | 1 | Fill in progress |
| irq | output | 1 | One-cycle completion pulse |
| ctrl_out | output | 32 | Captured control word, bit 24 cleared on completion |

## Verification
Two events can fall in the same cycle: the acceptance of the final entry and a new `start` request, or a stall on `wr_ready` just before the terminator. The bench holds `wr_ready` high, lets it toggle at random, or alternates it each cycle. It also pulses `start` with a different request part-way through a fill. A behavioural model, stepped on every clock, says whether the late `start` must be ignored and exactly which cycle carries the completion pulse. The model is compared against every output in every cycle. A run whose base address is near zero makes the pointers wrap through the top of the 24-bit space.

// File: rtl/otc_pkg.sv
package otc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } otc_state_e;
endpackage

// File: rtl/otc_mode_check.sv
module otc_mode_check #(
  parameter int unsigned CTRL_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter logic [CTRL_W-1:0] FILL_CODE = 32'h1100_0002
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [CNT_W-1:0]  entry_count,
  output logic              code_ok,
  output logic              accept
);
  // Only one exact control encoding starts a fill; a zero count is finished immediately.
  always_comb begin
    code_ok = (ctrl_word == FILL_CODE);
    accept  = code_ok && (entry_count != '0);
  end
endmodule

// File: rtl/otc_walker.sv
module otc_walker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  entry_count,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  left,
  output logic              last
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left     <= '0;
    end else if (load) begin
      cur_addr <= base_addr;
      left     <= entry_count;
    end else if (step && !last) begin
      cur_addr <= cur_addr - STRIDE;
      left     <= left - ONE;
    end
  end

  assign last = (left == ONE);

  // R4
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (cur_addr == $past(cur_addr) - STRIDE));

  // R3
  left_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left != '0));
endmodule

// File: rtl/otc_entry_fmt.sv
module otc_entry_fmt #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last,
  output logic [DATA_W-1:0] entry
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] END_MARK = '1;

  logic [ADDR_W-1:0] link;

  // The pointer field is address-sized; upper entry bits stay zero.
  always_comb begin
    link  = last ? END_MARK : (cur_addr - STRIDE);
    entry = '0;
    entry[ADDR_W-1:0] = link;
  end
endmodule

// File: rtl/otc_clear_engine.sv
module otc_clear_engine #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned RUN_BIT  = 24,
  parameter logic [CTRL_W-1:0] FILL_CODE = 32'h1100_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  entry_count,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              irq,
  output logic [CTRL_W-1:0] ctrl_out
);
  import otc_pkg::*;

  localparam logic [CTRL_W-1:0] RUN_MASK = CTRL_W'(1) << RUN_BIT;

  otc_state_e        state;
  logic              code_ok;
  logic              accept;
  logic              take;
  logic              load;
  logic              step;
  logic              finish;
  logic              last;
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] cur_addr;
  logic              irq_q;
  logic [CTRL_W-1:0] ctrl_q;

  otc_mode_check #(
    .CTRL_W(CTRL_W), .CNT_W(CNT_W), .FILL_CODE(FILL_CODE)
  ) u_mode (
    .ctrl_word(ctrl_word), .entry_count(entry_count),
    .code_ok(code_ok), .accept(accept)
  );

  assign take   = (state == ST_IDLE) && start;
  assign load   = take && accept;
  assign step   = (state == ST_FILL) && wr_ready;
  assign finish = step && last;

  otc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base_addr(base_addr), .entry_count(entry_count),
    .cur_addr(cur_addr), .left(left), .last(last)
  );

  otc_entry_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fmt (
    .cur_addr(cur_addr), .last(last), .entry(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      irq_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          if (accept) begin
            state  <= ST_FILL;
            ctrl_q <= ctrl_word;
          end else begin
            ctrl_q <= ctrl_word & ~RUN_MASK;
            irq_q  <= 1'b1;
          end
        end
        ST_FILL: if (finish) begin
          state          <= ST_IDLE;
          ctrl_q[RUN_BIT] <= 1'b0;
          irq_q          <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid = (state == ST_FILL);
  assign busy     = (state == ST_FILL);
  assign wr_addr  = cur_addr;
  assign irq      = irq_q;
  assign ctrl_out = ctrl_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq && !ctrl_out[RUN_BIT]));

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !code_ok) |=> (irq && !wr_valid && !ctrl_out[RUN_BIT]));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_ready && left == CNT_W'(1))) |=> busy);

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

// File: tb/sim_otc_clear_engine.sv
`timescale 1ns/1ps
module sim_otc_clear_engine;
  localparam logic [31:0] CODE = 32'h1100_0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] base_addr = '0;
  logic [15:0] entry_count = '0;
  logic [31:0] ctrl_word = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [23:0] wr_addr;
  logic [31:0] wr_data;
  logic        busy;
  logic        irq;
  logic [31:0] ctrl_out;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  int dut_writes = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] dmem [int];

  // behavioural reference state
  bit          m_busy = 1'b0;
  bit          m_irq = 1'b0;
  logic [23:0] m_addr = '0;
  int          m_left = 0;
  logic [31:0] m_ctrl = '0;

  always #2.5 clk = ~clk;

  otc_clear_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .entry_count(entry_count), .ctrl_word(ctrl_word), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .irq(irq), .ctrl_out(ctrl_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_entry();
    if (m_left == 1) return 32'h00FF_FFFF;
    return {8'h00, m_addr - 24'd4};
  endfunction

  // reference model and write capture
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_addr = '0; m_left = 0; m_ctrl = '0;
    end else begin
      bit nirq;
      if (wr_valid && wr_ready) begin
        dmem[int'(wr_addr)] = wr_data;
        dut_writes++;
      end
      nirq = 0;
      if (!m_busy) begin
        if (start) begin
          if (ctrl_word == CODE && entry_count != 0) begin
            m_busy = 1; m_addr = base_addr; m_left = int'(entry_count); m_ctrl = ctrl_word;
          end else begin
            m_ctrl = ctrl_word & ~32'h0100_0000;
            nirq = 1;
          end
        end
      end else if (wr_ready) begin
        if (m_left == 1) begin
          m_busy = 0; m_ctrl[24] = 1'b0; nirq = 1;
        end else begin
          m_addr = m_addr - 24'd4;
          m_left--;
        end
      end
      m_irq = nirq;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(busy == m_busy, "R10 busy", 64'(busy), 64'(m_busy));
      chk(wr_valid == m_busy, "R1 R9 wr_valid", 64'(wr_valid), 64'(m_busy));
      chk(irq == m_irq, "R7 R2 R8 irq", 64'(irq), 64'(m_irq));
      chk(ctrl_out == m_ctrl, "R7 ctrl_out", 64'(ctrl_out), 64'(m_ctrl));
      if (m_busy) begin
        chk(wr_addr == m_addr, "R4 R9 wr_addr", 64'(wr_addr), 64'(m_addr));
        chk(wr_data == m_entry(), (m_left == 1) ? "R6 end entry" : "R5 link entry",
            64'(wr_data), 64'(m_entry()));
      end
    end
  end

  // back-pressure patterns on the write port
  always @(negedge clk) begin
    case (ready_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = ($urandom_range(0, 2) != 0);
      default: wr_ready = ~wr_ready;
    endcase
  end

  task automatic run(input logic [23:0] b, input int n, input logic [31:0] c,
                     input int mode, input bit spur);
    int exp_n;
    int guard;
    ready_mode = mode;
    dmem.delete();
    dut_writes = 0;
    @(negedge clk);
    base_addr = b; entry_count = 16'(n); ctrl_word = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = 24'hABCDE0; entry_count = 16'd9; ctrl_word = 32'h0;
    if (spur) begin
      repeat (2) @(negedge clk);
      start = 1'b1; ctrl_word = CODE; entry_count = 16'd3; base_addr = 24'h005000;
      @(negedge clk);
      start = 1'b0;
      ctrl_word = 32'h1100_0005; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while ((m_busy || m_irq) && guard < 50000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    exp_n = (c == CODE) ? n : 0;
    chk(dut_writes == exp_n, (c != CODE) ? "R2 no writes" : (n == 0) ? "R8 no writes" : "R3 write count",
        64'(dut_writes), 64'(exp_n));
    for (int i = 0; i < exp_n; i++) begin
      logic [23:0] a;
      logic [31:0] e;
      a = b - 24'(4 * i);
      e = (i == exp_n - 1) ? 32'h00FF_FFFF : {8'h00, a - 24'd4};
      if (dmem.exists(int'(a)))
        chk(dmem[int'(a)] == e, (i == exp_n - 1) ? "R6 table end" : "R5 table link",
            64'(dmem[int'(a)]), 64'(e));
      else
        chk(1'b0, "R4 entry missing", 64'(a), 64'(e));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !irq && ctrl_out == '0, "R11 reset state",
        {wr_valid, busy, irq, ctrl_out}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !busy && !irq && ctrl_out == '0, "R11 after reset",
        {wr_valid, busy, irq, ctrl_out}, 64'h0);
    cmp_en = 1'b1;
    run(24'h001000, 8, CODE, 0, 1'b0);
    run(24'h002000, 5, CODE, 1, 1'b0);
    run(24'h000100, 1, CODE, 2, 1'b0);
    run(24'h003000, 0, CODE, 0, 1'b0);
    run(24'h004000, 6, 32'h1100_0003, 0, 1'b0);
    run(24'h004000, 4, 32'h0100_0002, 1, 1'b0);
    run(24'h000008, 4, CODE, 1, 1'b0);
    run(24'h006000, 7, CODE, 2, 1'b1);
    run(24'h007000, 12, CODE, 1, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule